// File: doc/BRIEF.md
# Packed-Calendar Timekeeping Counter Core

This block is the counting heart of a real-time clock. It keeps hundredths of a second, seconds, minutes and hours in BCD, then date, month, a two-bit year and a weekday. The date shares one byte with the year, and the month shares another byte with the weekday. The count advances from one of three sources, chosen by a field in the control byte. The first is a stream of crystal pulses, which an exact fractional prescaler turns into an average of 100 hundredth-ticks per second. The second is an external 50 Hz reference, where each pulse is worth two hundredths. The third is a raw event strobe. In event mode the low three bytes form a six-digit BCD event counter that each strobe increments directly, and the prescaler is bypassed.

Software reaches the block through a simple byte port: address, write data, write enable and a combinational read data bus. A stop flag freezes all counting so that a time can be loaded safely. A mask flag hides the year and weekday bits when the packed bytes are read, so that software sees only the date and the month.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the control byte reads 00, addresses 01 to 04 read 00, address 05 reads 01 and address 06 reads 01. This means crystal mode, running, unmasked, date 01, month 01, year 0 and weekday 0.
- R2: In crystal mode (mode field 00) the hundredths advance once each time the accumulated count of crystal pulses times 100 crosses a multiple of 32768. Starting from reset, 327 pulses leave hundredths at 00 and the 328th pulse makes them 01. After 32768 pulses the counter has advanced by exactly 100 hundredths: hundredths read 00 and seconds read 01.
- R3: In reference mode (mode field 01) each pulse on the reference input adds 2 to the hundredths.
- R4: The BCD counters at 01 (hundredths, 00 to 99), 02 (seconds, 00 to 59), 03 (minutes, 00 to 59) and 04 (hours, 00 to 23) each wrap to 00 and carry into the next. An hours wrap advances the date.
- R5: The date wraps to 01 after the last day of its month, and the month then advances. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the year is 0 and 28 days otherwise. All other months have 31 days. Month 12 wraps to 01 and increments the year modulo 4.
- R6: Each date increment advances the weekday by one, and weekday 6 wraps to 0.
- R7: Address 05 holds the year in bits 7:6 and the BCD date in bits 5:0. Address 06 holds the weekday in bits 7:5 and the BCD month in bits 4:0. Both bytes are written and read as whole bytes.
- R8: While the mask flag is set, reads of address 05 return bits 7:6 as zero and reads of address 06 return bits 7:5 as zero. The other bits are unchanged.
- R9: In event mode (mode field 10) each event strobe increments a six-digit BCD count. Digits D1:D0 are at 01, D3:D2 at 02 and D5:D4 at 03. The count wraps from 999999 to 000000. Crystal pulses have no effect in this mode, and addresses 04 to 06 hold their values.
- R10: While the stop flag is set, no counter changes on any input pulse, but register writes still take effect.
- R11: A write to a counter address updates that byte on the next clock edge and overrides a tick arriving at that byte in the same cycle.
- R12: The control byte at address 00 has the stop flag at bit 7, the mode field at bits 5:4 and the mask flag at bit 3. Its other bits read as zero. Mode field 11 counts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_pulse | input | 1 | One-cycle strobe per crystal period |
| ref_pulse | input | 1 | One-cycle strobe per 50 Hz reference period |
| evt_pulse | input | 1 | One-cycle strobe per counted event |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write enable for the addressed byte |
| rdata | output | 8 | Combinational read data for the addressed byte |

## Verification
A wrong prescaler phase shows up as the first hundredth arriving one pulse early or late, or as a long pulse run that drifts away from exactly 100 ticks. Checking the 328th pulse and the 32768th pulse catches both. A wrong month-length or carry state stays hidden until the one tick that crosses a date boundary, so the bench sweeps every month against every year value across that tick, and also one day earlier. A broken weekday, mask or write-priority path shows on the very next read of the affected byte.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   typedef enum logic [1:0] {
      SRC_XTAL  = 2'b00,
      SRC_REF   = 2'b01,
      SRC_EVENT = 2'b10,
      SRC_HALT  = 2'b11
   } src_e;

   localparam int STEP_W = 2;
   localparam int N_STG  = 4;

   localparam int A_CTRL   = 0;
   localparam int A_HUND   = 1;
   localparam int A_DATEYR = 5;
   localparam int A_MONWD  = 6;

   function automatic logic [6:0] bcd2bin(input logic [7:0] b);
      return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
   endfunction

   function automatic logic [7:0] bin2bcd(input logic [6:0] v);
      return {4'(v / 7'd10), 4'(v % 7'd10)};
   endfunction

   function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [1:0] yr);
      case (mon)
         5'h02:                      return (yr == 2'd0) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
   import rtc_cal_pkg::*;
#(
   parameter int XTAL_HZ = 32768,
   parameter int TICK_HZ = 100,
   parameter int REF_HZ  = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  src_e              src,
   input  logic              xtal_pulse,
   input  logic              ref_pulse,
   input  logic              evt_pulse,
   output logic              tick,
   output logic [STEP_W-1:0] step
);
   localparam int ACC_W    = $clog2(XTAL_HZ + TICK_HZ);
   localparam int REF_STEP = TICK_HZ / REF_HZ;

   if (TICK_HZ >= XTAL_HZ) begin : g_bad_ratio
      $error("tick rate must be below crystal rate");
   end
   if ((TICK_HZ % REF_HZ) != 0 || REF_STEP >= (1 << STEP_W)) begin : g_bad_ref
      $error("reference rate must divide tick rate into a small step");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;
   logic             acc_wrap;

   assign acc_sum  = acc_q + ACC_W'(TICK_HZ);
   assign acc_wrap = acc_sum >= ACC_W'(XTAL_HZ);

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else if (run && src == SRC_XTAL && xtal_pulse)
         acc_q <= acc_wrap ? acc_sum - ACC_W'(XTAL_HZ) : acc_sum;
   end

   always_comb begin
      tick = 1'b0;
      step = STEP_W'(1);
      case (src)
         SRC_XTAL:  tick = run && xtal_pulse && acc_wrap;
         SRC_REF:   begin tick = run && ref_pulse; step = STEP_W'(REF_STEP); end
         SRC_EVENT: tick = run && evt_pulse;
         default:   tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/rtc_bcd_stage.sv
module rtc_bcd_stage
   import rtc_cal_pkg::*;
(
   input  logic [7:0]        cur,
   input  logic              en,
   input  logic [STEP_W-1:0] step,
   input  logic [6:0]        limit,
   output logic [7:0]        nxt,
   output logic              carry
);
   logic [7:0] sum;

   always_comb begin
      sum   = {1'b0, bcd2bin(cur)} + 8'(step);
      nxt   = cur;
      carry = 1'b0;
      if (en) begin
         if (sum > {1'b0, limit}) begin
            nxt   = bin2bcd(7'(sum - {1'b0, limit} - 8'd1));
            carry = 1'b1;
         end else begin
            nxt = bin2bcd(sum[6:0]);
         end
      end
   end
endmodule

// File: rtl/rtc_calendar_unit.sv
module rtc_calendar_unit
   import rtc_cal_pkg::*;
(
   input  logic       inc,
   input  logic [5:0] date,
   input  logic [4:0] month,
   input  logic [1:0] year,
   input  logic [2:0] wday,
   output logic [5:0] date_n,
   output logic [4:0] month_n,
   output logic [1:0] year_n,
   output logic [2:0] wday_n
);
   logic [5:0] last;

   always_comb begin
      last    = last_day(month, year);
      date_n  = date;
      month_n = month;
      year_n  = year;
      wday_n  = wday;
      if (inc) begin
         wday_n = (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
         if (date >= last) begin
            date_n = 6'h01;
            if (month >= 5'h12) begin
               month_n = 5'h01;
               year_n  = year + 2'd1;
            end else begin
               month_n = 5'(bin2bcd(bcd2bin({3'b0, month}) + 7'd1));
            end
         end else begin
            date_n = 6'(bin2bcd(bcd2bin({2'b0, date}) + 7'd1));
         end
      end
   end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int XTAL_HZ = 32768,
   parameter int TICK_HZ = 100,
   parameter int REF_HZ  = 50,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xtal_pulse,
   input  logic              ref_pulse,
   input  logic              evt_pulse,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              we,
   output logic [7:0]        rdata
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("address must reach byte 6");
   end

   logic       stop_q, mask_q;
   src_e       src_q;
   logic [7:0] cnt_q   [N_STG];
   logic [7:0] cnt_nxt [N_STG];
   logic [N_STG-1:0] carry;
   logic [5:0] date_q, date_n;
   logic [4:0] month_q, month_n;
   logic [1:0] year_q, year_n;
   logic [2:0] wday_q, wday_n;
   logic              tick, evt_mode, day_inc;
   logic [STEP_W-1:0] tick_step;

   assign evt_mode = (src_q == SRC_EVENT);

   rtc_tick_gen #(.XTAL_HZ(XTAL_HZ), .TICK_HZ(TICK_HZ), .REF_HZ(REF_HZ)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(!stop_q), .src(src_q),
      .xtal_pulse(xtal_pulse), .ref_pulse(ref_pulse), .evt_pulse(evt_pulse),
      .tick(tick), .step(tick_step)
   );

   for (genvar i = 0; i < N_STG; i++) begin : g_stg
      localparam int LIM_T = (i == 0) ? 99 : ((i == N_STG - 1) ? 23 : 59);
      logic              en_s;
      logic [STEP_W-1:0] step_s;
      logic [6:0]        lim_s;
      if (i == 0) begin : g_first
         assign en_s   = tick;
         assign step_s = tick_step;
      end else if (i == N_STG - 1) begin : g_top
         assign en_s   = carry[i-1] && !evt_mode;
         assign step_s = STEP_W'(1);
      end else begin : g_mid
         assign en_s   = carry[i-1];
         assign step_s = STEP_W'(1);
      end
      if (i == N_STG - 1) begin : g_lim_fixed
         assign lim_s = 7'(LIM_T);
      end else begin : g_lim_mode
         assign lim_s = evt_mode ? 7'd99 : 7'(LIM_T);
      end
      rtc_bcd_stage u_stage (
         .cur(cnt_q[i]), .en(en_s), .step(step_s), .limit(lim_s),
         .nxt(cnt_nxt[i]), .carry(carry[i])
      );
   end

   assign day_inc = carry[N_STG-1];

   rtc_calendar_unit u_cal (
      .inc(day_inc), .date(date_q), .month(month_q), .year(year_q), .wday(wday_q),
      .date_n(date_n), .month_n(month_n), .year_n(year_n), .wday_n(wday_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q  <= 1'b0;
         mask_q  <= 1'b0;
         src_q   <= SRC_XTAL;
         for (int k = 0; k < N_STG; k++) cnt_q[k] <= 8'h00;
         date_q  <= 6'h01;
         month_q <= 5'h01;
         year_q  <= 2'd0;
         wday_q  <= 3'd0;
      end else begin
         for (int k = 0; k < N_STG; k++)
            cnt_q[k] <= (we && addr == ADDR_W'(A_HUND + k)) ? wdata : cnt_nxt[k];
         if (we && addr == ADDR_W'(A_CTRL)) begin
            stop_q <= wdata[7];
            src_q  <= src_e'(wdata[5:4]);
            mask_q <= wdata[3];
         end
         if (we && addr == ADDR_W'(A_DATEYR))
            {year_q, date_q} <= wdata;
         else
            {year_q, date_q} <= {year_n, date_n};
         if (we && addr == ADDR_W'(A_MONWD))
            {wday_q, month_q} <= wdata;
         else
            {wday_q, month_q} <= {wday_n, month_n};
      end
   end

   always_comb begin
      rdata = 8'h00;
      if (addr == ADDR_W'(A_CTRL))
         rdata = {stop_q, 1'b0, src_q, mask_q, 3'b000};
      else if (addr == ADDR_W'(A_DATEYR))
         rdata = {mask_q ? 2'b00 : year_q, date_q};
      else if (addr == ADDR_W'(A_MONWD))
         rdata = {mask_q ? 3'b000 : wday_q, month_q};
      else
         for (int k = 0; k < N_STG; k++)
            if (addr == ADDR_W'(A_HUND + k)) rdata = cnt_q[k];
   end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              stop,
   input logic              mask,
   input logic [1:0]        src,
   input logic [31:0]       cnt_flat,
   input logic [5:0]        date,
   input logic [4:0]        month,
   input logic [1:0]        year,
   input logic [2:0]        wday,
   input logic              day_inc
);
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !we) |=> ($stable(cnt_flat) && $stable({year, date, month, wday}))); // R10

   AST_MASK_DATE: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && addr == ADDR_W'(5)) |-> (rdata[7:6] == 2'b00)); // R8

   AST_MASK_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && addr == ADDR_W'(6)) |-> (rdata[7:5] == 3'b000)); // R8

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(1)) |=> (cnt_flat[7:0] == $past(wdata))); // R11

   AST_EVENT_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (src == 2'b10 && !we) |=> $stable({cnt_flat[31:24], year, date, month, wday})); // R9

   AST_WDAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (day_inc && !(we && addr == ADDR_W'(6))) |=>
      (wday == (($past(wday) >= 3'd6) ? 3'd0 : 3'($past(wday) + 3'd1)))); // R6
endmodule

bind rtc_calendar_core rtc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
   .stop(stop_q), .mask(mask_q), .src(src_q),
   .cnt_flat({cnt_q[3], cnt_q[2], cnt_q[1], cnt_q[0]}),
   .date(date_q), .month(month_q), .year(year_q), .wday(wday_q), .day_inc(day_inc)
);

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xtal_pulse = 1'b0, ref_pulse = 1'b0, evt_pulse = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       we = 1'b0;
   logic [7:0] rdata;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   rtc_calendar_core dut (
      .clk(clk), .rst_n(rst_n), .xtal_pulse(xtal_pulse), .ref_pulse(ref_pulse),
      .evt_pulse(evt_pulse), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata)
   );

   function automatic logic [7:0] tobcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic rdchk(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a;
      #1 chk(tag, rdata, exp);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic pulse(input int kind, input int n);
      @(negedge clk);
      if (kind == 0) xtal_pulse = 1'b1; else if (kind == 1) ref_pulse = 1'b1; else evt_pulse = 1'b1;
      repeat (n) @(negedge clk);
      xtal_pulse = 1'b0; ref_pulse = 1'b0; evt_pulse = 1'b0;
   endtask

   task automatic load(input logic [7:0] run_ctrl, input logic [7:0] hr, input logic [7:0] mi,
                       input logic [7:0] se, input logic [7:0] hs,
                       input logic [7:0] b5, input logic [7:0] b6);
      wr(4'd0, run_ctrl | 8'h80);
      wr(4'd1, hs); wr(4'd2, se); wr(4'd3, mi); wr(4'd4, hr);
      wr(4'd5, b5); wr(4'd6, b6);
      wr(4'd0, run_ctrl);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rdchk(4'd0, 8'h00, "R1 ctrl");
      rdchk(4'd1, 8'h00, "R1 hund");
      rdchk(4'd4, 8'h00, "R1 hour");
      rdchk(4'd5, 8'h01, "R1 date/year");
      rdchk(4'd6, 8'h01, "R1 month/wday");

      // R2 fractional prescaler
      pulse(0, 327);
      rdchk(4'd1, 8'h00, "R2 after 327");
      pulse(0, 1);
      rdchk(4'd1, 8'h01, "R2 after 328");
      pulse(0, 32768 - 328);
      rdchk(4'd1, 8'h00, "R2 hund after 32768");
      rdchk(4'd2, 8'h01, "R2 sec after 32768");

      // R3 reference mode adds two
      load(8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
      pulse(1, 49);
      rdchk(4'd1, 8'h98, "R3 49 ref pulses");
      pulse(1, 1);
      rdchk(4'd1, 8'h00, "R3 wrap hund");
      rdchk(4'd2, 8'h01, "R3 carry sec");

      // R4 full carry chain into date
      load(8'h10, 8'h23, 8'h59, 8'h59, 8'h98, 8'h45, 8'h43);
      pulse(1, 1);
      rdchk(4'd1, 8'h00, "R4 hund");
      rdchk(4'd2, 8'h00, "R4 sec");
      rdchk(4'd3, 8'h00, "R4 min");
      rdchk(4'd4, 8'h00, "R4 hour");
      rdchk(4'd5, 8'h46, "R4 date");
      rdchk(4'd6, 8'h63, "R4 wday");

      // R5 R6 sweep every month for every year
      for (int y = 0; y < 4; y++) begin
         for (int m = 1; m <= 12; m++) begin
            int last, wd, wdn, mn, yn;
            last = (m == 2) ? ((y == 0) ? 29 : 28) :
                   ((m == 4 || m == 6 || m == 9 || m == 11) ? 30 : 31);
            wd  = (m + y) % 7;
            wdn = (wd == 6) ? 0 : wd + 1;
            mn  = (m == 12) ? 1 : m + 1;
            yn  = (m == 12) ? (y + 1) % 4 : y;
            load(8'h10, 8'h23, 8'h59, 8'h59, 8'h98,
                 8'((y << 6) | tobcd(last - 1)), 8'((wd << 5) | tobcd(m)));
            pulse(1, 1);
            rdchk(4'd5, 8'((y << 6) | tobcd(last)), "R5 day before last");
            rdchk(4'd6, 8'((wdn << 5) | tobcd(m)), "R6 weekday step");
            load(8'h10, 8'h23, 8'h59, 8'h59, 8'h98,
                 8'((y << 6) | tobcd(last)), 8'((wd << 5) | tobcd(m)));
            pulse(1, 1);
            rdchk(4'd5, 8'((yn << 6) | 1), "R5 month end date/year");
            rdchk(4'd6, 8'((wdn << 5) | tobcd(mn)), "R5 month end month");
         end
      end

      // R7 packing, R8 mask, R12 control layout
      wr(4'd0, 8'h90);
      wr(4'd5, 8'hD7);
      wr(4'd6, 8'hB1);
      rdchk(4'd5, 8'hD7, "R7 date/year byte");
      rdchk(4'd6, 8'hB1, "R7 month/wday byte");
      wr(4'd0, 8'h98);
      rdchk(4'd5, 8'h17, "R8 mask date");
      rdchk(4'd6, 8'h11, "R8 mask month");
      rdchk(4'd0, 8'h98, "R12 ctrl readback");
      wr(4'd0, 8'hFF);
      rdchk(4'd0, 8'hB8, "R12 reserved bits");

      // R10 stop holds, writes still land
      wr(4'd0, 8'h90);
      wr(4'd1, 8'h55);
      pulse(1, 10);
      pulse(0, 400);
      rdchk(4'd1, 8'h55, "R10 stop hold");

      // R9 event counter
      load(8'h20, 8'h12, 8'h99, 8'h99, 8'h99, 8'h45, 8'h43);
      pulse(2, 1);
      rdchk(4'd1, 8'h00, "R9 wrap D1D0");
      rdchk(4'd2, 8'h00, "R9 wrap D3D2");
      rdchk(4'd3, 8'h00, "R9 wrap D5D4");
      rdchk(4'd4, 8'h12, "R9 hour held");
      pulse(2, 1234);
      rdchk(4'd1, 8'h34, "R9 count D1D0");
      rdchk(4'd2, 8'h12, "R9 count D3D2");
      rdchk(4'd3, 8'h00, "R9 count D5D4");
      pulse(0, 500);
      rdchk(4'd1, 8'h34, "R9 crystal bypassed");
      rdchk(4'd5, 8'h45, "R9 date held");

      // R11 write beats same-cycle tick
      @(negedge clk);
      addr = 4'd1; wdata = 8'h42; we = 1'b1; evt_pulse = 1'b1;
      @(negedge clk);
      we = 1'b0; evt_pulse = 1'b0;
      rdchk(4'd1, 8'h42, "R11 write wins");
      rdchk(4'd2, 8'h12, "R11 no stray carry");

      // R12 mode 11 counts nothing
      wr(4'd0, 8'h30);
      pulse(0, 400); pulse(1, 10); pulse(2, 10);
      rdchk(4'd1, 8'h42, "R12 halt mode");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule